// File: doc/BRIEF.md
# Paged configuration image sequencer

This block holds up to eight configuration images of different sizes in one flat byte memory. It streams the chosen image to a chain of downstream programmable devices. A small table near a fixed base address gives each image a start address and a byte length. When the output-enable line rises, the block captures the three-bit image select. It then fetches that image's table entry through a synchronous-read memory port and plays the image out, byte by byte, on a valid/ready stream. Because every downstream device's image sits back to back inside one page, a single contiguous read configures the whole chain.

A reconfiguration request abandons whatever is in progress and returns the block to waiting for the next output-enable rise. The system can therefore change the select lines, assert the request and then raise output-enable again to boot from a different page, for example a fail-safe page after a corrupted update. A zero-length table entry raises an error flag instead of streaming.

Top module: `cfg_page_seq`

## Requirements
- R1: The select value k (page_sel[2] is the most significant bit) picks the table entry at byte address TBL_BASE + 8*k. The entry holds two 32-bit little-endian words: the start byte address at offsets 0..3, then the byte length at offsets 4..7.
- R2: page_sel is captured only on the cycle in which oe is high and was low on the previous cycle while the block is idle. Changing page_sel later in the cycle has no effect on the bytes streamed.
- R3: A select value of 0 streams page 0, the default page.
- R4: The stream carries exactly the length bytes found in memory from the start address upward, in ascending address order. The length comes from the table, so pages of different sizes stream different byte counts.
- R5: out_last is high together with out_valid on the final byte of the page and on no other byte. After that byte is accepted, out_valid stays low until a new cycle streams.
- R6: A table entry whose length is zero sets err. No byte is streamed, done does not pulse, and err stays set until the next cycle start clears it.
- R7: done is high for exactly one clock, on the cycle after the final byte is accepted. The block is then idle, and the next oe rise starts another cycle. After reset, out_valid, done and err are low.
- R8: While out_valid is high and out_ready is low, out_data and out_last hold steady. No byte is dropped or repeated under any pattern of out_ready.
- R9: On the cycle after reconfig_req is high, out_valid and mem_rd are low. Nothing further streams until oe rises again, and that rise captures a fresh page_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oe | input | 1 | Output enable; its rising edge starts a configuration cycle |
| page_sel | input | SEL_W | Page select, captured at cycle start |
| reconfig_req | input | 1 | Abort and wait for a new cycle start |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte valid |
| out_last | output | 1 | Final byte of the page |
| out_ready | input | 1 | Downstream accepts the byte |
| done | output | 1 | One-cycle pulse after the final byte |
| err | output | 1 | Selected page has zero length |

## Verification
Directed runs cover page 0, a page whose select differs only in its top bit, a one-byte page, a zero-length page and a mid-stream abort that switches to another page. Together these separate the table indexing, bit order, last-byte marking, error path and restart handling. Random runs then draw pages at random under three out_ready duty cycles while the select lines wander after cycle start. A lost or doubled byte under backpressure shows up as a compare mismatch against the bench's own memory model, and a late capture of the select shows up as the wrong page's bytes.

// File: rtl/cps_pkg.sv
`timescale 1ns/1ps
package cps_pkg;
   localparam int unsigned ENTRY_BYTES = 8;
   localparam int unsigned ENTRY_BITS  = 8 * ENTRY_BYTES;
   localparam int unsigned IDX_W       = $clog2(ENTRY_BYTES);

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_TABLE  = 2'd1,
      ST_STREAM = 2'd2
   } cps_state_e;
endpackage

// File: rtl/cps_tbl_fetch.sv
`timescale 1ns/1ps
module cps_tbl_fetch
   import cps_pkg::*;
#(
   parameter int unsigned AW       = 16,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned TBL_BASE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic [SEL_W-1:0] sel,
   input  logic [7:0]       rdata,
   output logic             rd,
   output logic [AW-1:0]    addr,
   output logic             fin,
   output logic [31:0]      start_word,
   output logic [31:0]      len_word
);
   logic                  active_q;
   logic [IDX_W:0]        icnt_q;
   logic                  pend_q;
   logic [IDX_W-1:0]      ridx_q;
   logic [SEL_W-1:0]      sel_q;
   logic [ENTRY_BITS-1:0] entry_q;
   logic                  fin_q;

   assign rd   = active_q && !icnt_q[IDX_W];
   assign addr = AW'(TBL_BASE) + AW'({sel_q, icnt_q[IDX_W-1:0]});

   always_ff @(posedge clk) begin
      if (!rst_n || abort) begin
         active_q <= 1'b0;
         icnt_q   <= '0;
         pend_q   <= 1'b0;
         ridx_q   <= '0;
         fin_q    <= 1'b0;
         if (!rst_n) begin
            sel_q   <= '0;
            entry_q <= '0;
         end
      end else begin
         pend_q <= rd;
         ridx_q <= icnt_q[IDX_W-1:0];
         fin_q  <= pend_q && (ridx_q == IDX_W'(ENTRY_BYTES - 1));
         if (pend_q)
            entry_q <= {rdata, entry_q[ENTRY_BITS-1:8]};
         if (start) begin
            active_q <= 1'b1;
            icnt_q   <= '0;
            sel_q    <= sel;
         end else begin
            if (rd)
               icnt_q <= icnt_q + 1'b1;
            if (fin_q)
               active_q <= 1'b0;
         end
      end
   end

   assign fin        = fin_q;
   assign start_word = entry_q[31:0];
   assign len_word   = entry_q[63:32];
endmodule

// File: rtl/cps_stream_gen.sv
`timescale 1ns/1ps
module cps_stream_gen #(
   parameter int unsigned AW    = 16,
   parameter int unsigned DEPTH = 2,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic [AW-1:0]    base,
   input  logic [31:0]      len,
   input  logic [CNT_W-1:0] fifo_cnt,
   input  logic             pop,
   output logic             rd,
   output logic [AW-1:0]    addr,
   output logic             push,
   output logic             push_last
);
   logic [AW-1:0] addr_q;
   logic [31:0]   remain_q;
   logic          pend_q;
   logic          pend_last_q;
   logic [CNT_W:0] occ;

   // slots taken after this cycle's pop, counting the byte in flight
   assign occ = {1'b0, fifo_cnt} + (CNT_W+1)'(pend_q) - (CNT_W+1)'(pop);
   assign rd  = (remain_q != 32'd0) && (occ < (CNT_W+1)'(DEPTH));
   assign addr      = addr_q;
   assign push      = pend_q;
   assign push_last = pend_last_q;

   always_ff @(posedge clk) begin
      if (!rst_n || abort) begin
         addr_q      <= '0;
         remain_q    <= '0;
         pend_q      <= 1'b0;
         pend_last_q <= 1'b0;
      end else if (start) begin
         addr_q      <= base;
         remain_q    <= len;
         pend_q      <= 1'b0;
         pend_last_q <= 1'b0;
      end else begin
         pend_q      <= rd;
         pend_last_q <= rd && (remain_q == 32'd1);
         if (rd) begin
            addr_q   <= addr_q + 1'b1;
            remain_q <= remain_q - 32'd1;
         end
      end
   end
endmodule

// File: rtl/cps_out_fifo.sv
`timescale 1ns/1ps
module cps_out_fifo #(
   parameter int unsigned W     = 9,
   parameter int unsigned DEPTH = 2,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1),
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [W-1:0]     din,
   input  logic             pop,
   output logic [W-1:0]     dout,
   output logic             valid,
   output logic [CNT_W-1:0] cnt
);
   logic [PTR_W-1:0]          wp_q, rp_q;
   logic [CNT_W-1:0]          cnt_q;
   logic [DEPTH-1:0][W-1:0]   slots;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("cps_out_fifo: DEPTH must be a power of two, at least 2");
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (push && wp_q == PTR_W'(g))
            slot_q <= din;
      end
      assign slots[g] = slot_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign dout  = slots[rp_q];
   assign valid = (cnt_q != '0);
   assign cnt   = cnt_q;
endmodule

// File: rtl/cfg_page_seq.sv
`timescale 1ns/1ps
module cfg_page_seq
   import cps_pkg::*;
#(
   parameter int unsigned AW         = 16,
   parameter int unsigned SEL_W      = 3,
   parameter int unsigned TBL_BASE   = 0,
   parameter int unsigned FIFO_DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             oe,
   input  logic [SEL_W-1:0] page_sel,
   input  logic             reconfig_req,
   output logic             mem_rd,
   output logic [AW-1:0]    mem_addr,
   input  logic [7:0]       mem_rdata,
   output logic [7:0]       out_data,
   output logic             out_valid,
   output logic             out_last,
   input  logic             out_ready,
   output logic             done,
   output logic             err
);
   localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

   initial begin
      assert (AW >= 8 && AW < 32) else $error("cfg_page_seq: AW out of range");
      assert (SEL_W + IDX_W <= AW) else $error("cfg_page_seq: table index too wide");
      assert (TBL_BASE + (ENTRY_BYTES << SEL_W) <= (1 << AW))
         else $error("cfg_page_seq: table does not fit in memory");
   end

   cps_state_e st_q;
   logic       oe_q, err_q, done_q;

   logic             tbl_rd, tbl_fin;
   logic [AW-1:0]    tbl_addr;
   logic [31:0]      tbl_start, tbl_len;
   logic             str_rd, str_push, str_push_last;
   logic [AW-1:0]    str_addr;
   logic [8:0]       fifo_dout;
   logic             fifo_valid;
   logic [CNT_W-1:0] fifo_cnt;
   logic             cyc_start, str_start, pop, fin_pop;
   logic             unused_hi;

   assign unused_hi = ^tbl_start[31:AW];

   assign cyc_start = (st_q == ST_IDLE) && oe && !oe_q && !reconfig_req;
   assign str_start = (st_q == ST_TABLE) && tbl_fin && (tbl_len != 32'd0);
   assign pop       = fifo_valid && out_ready;
   assign fin_pop   = pop && fifo_dout[8] && (st_q == ST_STREAM);

   cps_tbl_fetch #(.AW(AW), .SEL_W(SEL_W), .TBL_BASE(TBL_BASE)) u_tbl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (cyc_start),
      .abort      (reconfig_req),
      .sel        (page_sel),
      .rdata      (mem_rdata),
      .rd         (tbl_rd),
      .addr       (tbl_addr),
      .fin        (tbl_fin),
      .start_word (tbl_start),
      .len_word   (tbl_len)
   );

   cps_stream_gen #(.AW(AW), .DEPTH(FIFO_DEPTH)) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (str_start),
      .abort     (reconfig_req),
      .base      (tbl_start[AW-1:0]),
      .len       (tbl_len),
      .fifo_cnt  (fifo_cnt),
      .pop       (pop),
      .rd        (str_rd),
      .addr      (str_addr),
      .push      (str_push),
      .push_last (str_push_last)
   );

   cps_out_fifo #(.W(9), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (reconfig_req),
      .push  (str_push),
      .din   ({str_push_last, mem_rdata}),
      .pop   (pop),
      .dout  (fifo_dout),
      .valid (fifo_valid),
      .cnt   (fifo_cnt)
   );

   assign mem_rd   = tbl_rd | str_rd;
   assign mem_addr = tbl_rd ? tbl_addr : str_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         oe_q   <= 1'b0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         oe_q   <= oe;
         done_q <= fin_pop && !reconfig_req;
         if (reconfig_req) begin
            st_q <= ST_IDLE;
         end else begin
            unique case (st_q)
               ST_IDLE: if (cyc_start) begin
                  st_q  <= ST_TABLE;
                  err_q <= 1'b0;
               end
               ST_TABLE: if (tbl_fin) begin
                  if (tbl_len == 32'd0) begin
                     st_q  <= ST_IDLE;
                     err_q <= 1'b1;
                  end else begin
                     st_q <= ST_STREAM;
                  end
               end
               ST_STREAM: if (fin_pop) st_q <= ST_IDLE;
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign out_data  = fifo_dout[7:0];
   assign out_valid = fifo_valid;
   assign out_last  = fifo_dout[8] & fifo_valid;
   assign done      = done_q;
   assign err       = err_q;
endmodule

// File: rtl/cps_checker.sv
`timescale 1ns/1ps
module cps_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       reconfig_req,
   input logic       mem_rd,
   input logic [7:0] out_data,
   input logic       out_valid,
   input logic       out_last,
   input logic       out_ready,
   input logic       done,
   input logic       err
);
   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && !reconfig_req |=> out_valid && $stable(out_data) && $stable(out_last)) else $error("stall"); // R8
   AST_LAST_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> !out_valid) else $error("last"); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done width"); // R7
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(out_valid && out_ready && out_last)) else $error("done cause"); // R7
   AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !out_valid) else $error("err stream"); // R6
   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      reconfig_req |=> !out_valid && !mem_rd) else $error("abort"); // R9
endmodule

bind cfg_page_seq cps_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reconfig_req (reconfig_req),
   .mem_rd       (mem_rd),
   .out_data     (out_data),
   .out_valid    (out_valid),
   .out_last     (out_last),
   .out_ready    (out_ready),
   .done         (done),
   .err          (err)
);

// File: tb/cfg_page_seq_test.sv
`timescale 1ns/1ps
module cfg_page_seq_test;
   localparam int AW    = 12;
   localparam int MEMSZ = 1 << AW;
   localparam int CAPN  = 1024;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n, oe, reconfig_req, mem_rd, out_valid, out_last, out_ready, done, err;
   logic [2:0]    page_sel;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_rdata, out_data;
   logic [7:0]    mem [MEMSZ];

   cfg_page_seq #(.AW(AW), .SEL_W(3), .TBL_BASE(0), .FIFO_DEPTH(2)) uut (
      .clk(clk), .rst_n(rst_n), .oe(oe), .page_sel(page_sel), .reconfig_req(reconfig_req),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
      .done(done), .err(err));

   always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

   function automatic int pg_start(int k);
      case (k)
         0: return 'h100; 1: return 'h180; 2: return 'h1C0; 3: return 'h200;
         4: return 'h300; 5: return 'h3F0; 6: return 'h400; default: return 'hFF0;
      endcase
   endfunction
   function automatic int pg_len(int k);
      case (k)
         0: return 37; 1: return 1; 2: return 0; 3: return 200;
         4: return 64; 5: return 3; 6: return 500; default: return 13;
      endcase
   endfunction
   function automatic logic [7:0] byte_at(int a);
      return 8'((a * 13) ^ (a >> 5) ^ 'h5A);
   endfunction

   int nchk = 0, nerr = 0, cyc = 0;
   int ncap, done_cnt, done_bad, last_hs_cyc, ready_pct;
   logic [7:0] cap [CAPN];
   logic       cap_last [CAPN];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clear_cap();
      ncap = 0; done_cnt = 0; done_bad = 0; last_hs_cyc = -10;
   endtask

   initial begin
      out_ready = 1'b0;
      forever begin
         @(posedge clk); #1;
         out_ready = (($urandom % 100) < ready_pct);
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n === 1'b1) begin
            if (done) begin
               done_cnt++;
               if (cyc != last_hs_cyc + 1) done_bad++;
            end
            if (out_valid && out_ready) begin
               if (ncap < CAPN) begin
                  cap[ncap] = out_data;
                  cap_last[ncap] = out_last;
               end
               ncap++;
               if (out_last) last_hs_cyc = cyc;
            end
         end
      end
   end

   task automatic start_cycle(input int sel);
      page_sel = 3'(sel);
      oe = 1'b0;
      step(1);
      oe = 1'b1;
      step(1);
   endtask

   task automatic wait_end();
      for (int i = 0; i < 8000; i++) begin
         @(negedge clk);
         if (done_cnt > 0 || err) break;
      end
      step(3);
   endtask

   task automatic check_page(input int sel, input string tag);
      int len, st, mism, lastbad;
      len = pg_len(sel);
      st  = pg_start(sel);
      if (len == 0) begin
         check(err == 1'b1, "R6 err on zero length", int'(err), 1);
         check(ncap == 0 && done_cnt == 0, "R6 no bytes no done", ncap + done_cnt, 0);
      end else begin
         mism = 0; lastbad = 0;
         check(ncap == len, {tag, " byte count"}, ncap, len);
         for (int i = 0; i < len && i < ncap && i < CAPN; i++) begin
            if (cap[i] !== byte_at(st + i)) mism++;
            if (cap_last[i] !== (i == len - 1)) lastbad++;
         end
         check(mism == 0, {tag, " page content"}, mism, 0);
         check(lastbad == 0, "R5 last marking", lastbad, 0);
         check(done_cnt == 1 && done_bad == 0, "R7 done pulse timing", done_cnt * 10 + done_bad, 10);
         check(err == 1'b0, "R6 err clear on good page", int'(err), 0);
      end
      oe = 1'b0;
      step(2);
   endtask

   task automatic run_page(input int sel, input int pct, input bit wander, input string tag);
      ready_pct = pct;
      clear_cap();
      start_cycle(sel);
      if (wander) begin
         step(2);
         page_sel = 3'($urandom);
         step(20);
         page_sel = ~3'(sel);
      end
      wait_end();
      check_page(sel, tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      void'($urandom(32'd4417));
      for (int a = 0; a < MEMSZ; a++) mem[a] = byte_at(a);
      for (int k = 0; k < 8; k++)
         for (int b = 0; b < 4; b++) begin
            mem[8*k + b]     = 8'(pg_start(k) >> (8*b));
            mem[8*k + 4 + b] = 8'(pg_len(k) >> (8*b));
         end
      rst_n = 1'b0; oe = 1'b0; page_sel = 3'd0; reconfig_req = 1'b0; ready_pct = 100;
      clear_cap();
      step(5);
      check(out_valid == 1'b0 && done == 1'b0, "R7 reset idle outputs", int'(out_valid) + int'(done), 0);
      check(err == 1'b0, "R6 reset err low", int'(err), 0);
      check(mem_rd == 1'b0, "R9 reset no reads", int'(mem_rd), 0);
      rst_n = 1'b1;
      step(2);

      run_page(0, 100, 1'b0, "R3 default page");
      run_page(4, 100, 1'b0, "R1 top select bit");
      run_page(1, 100, 1'b0, "R5 single byte page");
      run_page(2, 100, 1'b0, "R6 zero length");
      run_page(5, 100, 1'b0, "R6 next start");
      run_page(3, 30, 1'b1, "R2 select ignored mid cycle R8");

      // abort mid-stream and restart from another page
      ready_pct = 100;
      clear_cap();
      start_cycle(6);
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (ncap >= 20) break;
      end
      step(1);
      reconfig_req = 1'b1;
      page_sel = 3'd7;
      step(1);
      reconfig_req = 1'b0;
      check(out_valid == 1'b0 && mem_rd == 1'b0, "R9 abort quiets outputs", int'(out_valid) + int'(mem_rd), 0);
      clear_cap();
      step(12);
      check(ncap == 0 && mem_rd == 1'b0, "R9 no restart without oe rise", ncap, 0);
      start_cycle(7);
      wait_end();
      check_page(7, "R9 fresh select after abort");

      for (int n = 0; n < 24; n++) begin
         int sel, pct;
         sel = int'($urandom % 8);
         case ($urandom % 3)
            0: pct = 100;
            1: pct = 60;
            default: pct = 25;
         endcase
         run_page(sel, pct, bit'($urandom % 2), "R4 random page R8");
      end

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule